// File: doc/BRIEF.md
# E1 Timeslot-0 Overhead Bit Extractor

This block sits behind an E1 receive framer that has already found frame alignment. The framer supplies the received bit stream, one bit per clock, together with a strobe on the first bit of each 256-bit frame and a flag that tells whether that frame is an align frame or a non-align frame. The block passes the whole stream through unchanged on a link data output. It also drives a gated link clock that is high only on the national bits the host has enabled, so a downstream serial consumer can pick out just those bits. A frame-marker output is aligned with the international bit.

The block also assembles the timeslot-0 byte of every frame. Once per double frame (an align frame followed by a non-align frame) it copies both bytes into host-readable capture registers and sets a sticky update flag. The host then has one double frame, 250 us, to read the pair before the next update replaces it. If a new update arrives while the flag is still set, an overrun flag is raised. When a frame strobe goes missing, the block keeps its own count and keeps alternating the frame type.

Top module: `e1_ts0_extract`

## Requirements
- R1: `link_data` equals `rx_data` one clock later on every cycle, before frame lock as well as after it, whatever the value of `sa_mask`.
- R2: `sync_out` is high for exactly one cycle, one clock after `frame_strobe`. It marks the cycle in which `link_data` carries the international bit (frame bit time 0).
- R3: In a non-align frame, `link_clk` is high in the cycle in which `link_data` carries national bit Sa(4+i), at frame bit time 3+i, exactly when `sa_mask[i]` is 1 (i = 0..4, so bit 0 selects Sa4 and bit 4 selects Sa8). In every other cycle of that frame it is low.
- R4: `link_clk` stays low in align frames and before the first `frame_strobe`, and it is never high together with `sync_out`.
- R5: The first timeslot-0 bit received (the international bit, bit time 0) lands in bit 7 of a captured byte and the eighth bit (bit time 7) lands in bit 0. `af_byte` holds the byte of the align frame and `naf_byte` holds the byte of the non-align frame, both unmodified.
- R6: Both capture registers and the update flag change together on the clock edge that ends bit time 7 of a non-align frame, and only when the frame just before it was an align frame. A non-align frame that follows anything else updates nothing.
- R7: `af_flag` stays set until `host_ack` is high for a cycle, which clears it. If an update occurs in that same cycle, the flag stays set.
- R8: An update that finds `af_flag` already set, with `host_ack` low, sets the sticky `overrun`. `host_ack` clears `overrun`.
- R9: `frame_strobe` resets the bit position to 0 and loads the frame type from `align_frame`. Without a strobe, the position wraps after 256 bits and the frame type toggles, so extraction and capture carry on.
- R10: While reset is asserted, and right after it is released, `link_data`, `link_clk`, `sync_out`, `af_flag`, `overrun`, `af_byte` and `naf_byte` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock, one bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 1 | Aligned received bit |
| frame_strobe | input | 1 | High on bit time 0 of a frame |
| align_frame | input | 1 | Frame type, sampled with `frame_strobe` (1 = align frame) |
| sa_mask | input | 5 | Link clock enable, bit i for Sa(4+i) |
| host_ack | input | 1 | Clears `af_flag` and `overrun` |
| link_data | output | 1 | Received stream delayed by one clock |
| link_clk | output | 1 | Gated pulse on the selected national bits |
| sync_out | output | 1 | Frame marker aligned with the international bit |
| af_byte | output | 8 | Captured align-frame timeslot-0 byte |
| naf_byte | output | 8 | Captured non-align-frame timeslot-0 byte |
| af_flag | output | 1 | Sticky double-frame update flag |
| overrun | output | 1 | Sticky flag: an update found the previous one unread |

## Verification
The checker watches, on every cycle, the one-clock mirror of the data stream, that the link clock never coincides with the frame marker, that the update flag holds until acknowledged, that an acknowledge clears overrun, that overrun only rises over a flag that was already set, and that the capture registers move only while the flag is up. Only the bench scenarios can show where in the frame the link clock pulses for each of the 32 mask values, that align frames and unlocked periods stay silent, the bit order of the captured bytes, that a non-align frame with no align frame before it is ignored, and that free-running framing across a missing strobe still lands on the right bits.

// File: rtl/e1_ts0_pkg.sv
package e1_ts0_pkg;
  // Timeslot 0 occupies the first bit times of every frame.
  parameter int unsigned TS0_BITS     = 8;
  // Number of national bits and the bit time of the first one.
  parameter int unsigned SA_COUNT     = 5;
  parameter int unsigned SA_FIRST_POS = 3;

  typedef logic [TS0_BITS-1:0] ts0_byte_t;
endpackage

// File: rtl/e1_bit_timer.sv
// Tracks the bit position inside the frame and the align/non-align type.
module e1_bit_timer #(
  parameter int unsigned FRAME_BITS = 256,
  parameter int unsigned POS_W      = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_strobe,
  input  logic             align_frame,
  output logic [POS_W-1:0] pos_now,
  output logic             in_frame,
  output logic             align_now
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  logic [POS_W-1:0] pos_q;
  logic             align_q;
  logic             locked_q;
  logic             locked_d;
  logic             wrap;

  always_comb begin
    wrap     = (pos_q == LAST_POS);
    locked_d = locked_q | frame_strobe;
    in_frame = locked_d;
    if (frame_strobe) begin
      pos_now   = '0;
      align_now = align_frame;
    end else if (wrap) begin
      pos_now   = '0;
      align_now = ~align_q;
    end else begin
      pos_now   = pos_q + 1'b1;
      align_now = align_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q    <= LAST_POS;
      align_q  <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      locked_q <= locked_d;
      if (in_frame) begin
        pos_q   <= pos_now;
        align_q <= align_now;
      end
    end
  end
endmodule

// File: rtl/e1_link_gate.sv
// Drives the delayed data stream, the frame marker and the gated link clock.
module e1_link_gate
  import e1_ts0_pkg::*;
#(
  parameter int unsigned POS_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_data,
  input  logic                frame_strobe,
  input  logic                in_frame,
  input  logic                align_now,
  input  logic [POS_W-1:0]    pos_now,
  input  logic [SA_COUNT-1:0] sa_mask,
  output logic                link_data,
  output logic                link_clk,
  output logic                sync_out
);
  logic [SA_COUNT-1:0] sa_hit;
  logic                clk_d;

  for (genvar i = 0; i < SA_COUNT; i++) begin : g_sa
    assign sa_hit[i] = sa_mask[i] & (pos_now == POS_W'(SA_FIRST_POS + i));
  end

  always_comb begin
    clk_d = in_frame & ~align_now & (|sa_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_data <= 1'b0;
      link_clk  <= 1'b0;
      sync_out  <= 1'b0;
    end else begin
      link_data <= rx_data;
      link_clk  <= clk_d;
      sync_out  <= frame_strobe;
    end
  end
endmodule

// File: rtl/e1_ts0_capture.sv
// Assembles timeslot-0 bytes and latches the pair once per double frame.
module e1_ts0_capture
  import e1_ts0_pkg::*;
#(
  parameter int unsigned POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_data,
  input  logic             in_frame,
  input  logic             align_now,
  input  logic [POS_W-1:0] pos_now,
  input  logic             host_ack,
  output ts0_byte_t        af_byte,
  output ts0_byte_t        naf_byte,
  output logic             af_flag,
  output logic             overrun
);
  localparam logic [POS_W-1:0] TS0_END = POS_W'(TS0_BITS - 1);
  localparam logic [POS_W-1:0] TS0_LEN = POS_W'(TS0_BITS);

  ts0_byte_t shift_q;
  ts0_byte_t byte_now;
  ts0_byte_t hold_q;
  logic      pend_q;
  logic      pend_d;
  logic      in_ts0;
  logic      ts0_last;
  logic      hold_en;
  logic      upd;
  logic      flag_d;
  logic      ovr_d;

  always_comb begin
    in_ts0   = in_frame & (pos_now < TS0_LEN);
    ts0_last = in_frame & (pos_now == TS0_END);
    byte_now = {shift_q[TS0_BITS-2:0], rx_data};
    hold_en  = ts0_last & align_now;
    upd      = ts0_last & ~align_now & pend_q;
    pend_d   = ts0_last ? align_now : pend_q;

    if (upd)           flag_d = 1'b1;
    else if (host_ack) flag_d = 1'b0;
    else               flag_d = af_flag;

    if (upd & af_flag & ~host_ack) ovr_d = 1'b1;
    else if (host_ack)             ovr_d = 1'b0;
    else                           ovr_d = overrun;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '0;
      hold_q   <= '0;
      pend_q   <= 1'b0;
      af_byte  <= '0;
      naf_byte <= '0;
      af_flag  <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (in_ts0)  shift_q <= byte_now;
      if (hold_en) hold_q  <= byte_now;
      pend_q  <= pend_d;
      if (upd) begin
        af_byte  <= hold_q;
        naf_byte <= byte_now;
      end
      af_flag <= flag_d;
      overrun <= ovr_d;
    end
  end
endmodule

// File: rtl/e1_ts0_extract.sv
module e1_ts0_extract
  import e1_ts0_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_data,
  input  logic                frame_strobe,
  input  logic                align_frame,
  input  logic [SA_COUNT-1:0] sa_mask,
  input  logic                host_ack,
  output logic                link_data,
  output logic                link_clk,
  output logic                sync_out,
  output ts0_byte_t           af_byte,
  output ts0_byte_t           naf_byte,
  output logic                af_flag,
  output logic                overrun
);
  localparam int unsigned POS_W = $clog2(FRAME_BITS);

  logic             rst_m_n;
  logic             rst_q_n;
  logic [POS_W-1:0] pos_now;
  logic             in_frame;
  logic             align_now;

  // Reset asserts asynchronously and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_n <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_m_n <= 1'b1;
      rst_q_n <= rst_m_n;
    end
  end

  e1_bit_timer #(.FRAME_BITS(FRAME_BITS), .POS_W(POS_W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .frame_strobe (frame_strobe),
    .align_frame  (align_frame),
    .pos_now      (pos_now),
    .in_frame     (in_frame),
    .align_now    (align_now)
  );

  e1_link_gate #(.POS_W(POS_W)) u_gate (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .rx_data      (rx_data),
    .frame_strobe (frame_strobe),
    .in_frame     (in_frame),
    .align_now    (align_now),
    .pos_now      (pos_now),
    .sa_mask      (sa_mask),
    .link_data    (link_data),
    .link_clk     (link_clk),
    .sync_out     (sync_out)
  );

  e1_ts0_capture #(.POS_W(POS_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .rx_data   (rx_data),
    .in_frame  (in_frame),
    .align_now (align_now),
    .pos_now   (pos_now),
    .host_ack  (host_ack),
    .af_byte   (af_byte),
    .naf_byte  (naf_byte),
    .af_flag   (af_flag),
    .overrun   (overrun)
  );
endmodule

// File: rtl/e1_ts0_extract_chk.sv
module e1_ts0_extract_chk (
  input logic       clk,
  input logic       rst_q_n,
  input logic       rx_data,
  input logic       link_data,
  input logic       link_clk,
  input logic       sync_out,
  input logic       host_ack,
  input logic       af_flag,
  input logic       overrun,
  input logic [7:0] af_byte,
  input logic [7:0] naf_byte
);
  // R1: one-clock mirror of the received stream
  a_r1_data_mirror: assert property (@(posedge clk) disable iff (!rst_q_n)
    $past(rst_q_n) |-> (link_data == $past(rx_data)));

  // R4: link clock never on the international bit
  a_r4_clk_not_on_sync: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(link_clk && sync_out));

  // R7: flag holds until acknowledged
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_q_n)
    (af_flag && !host_ack) |=> af_flag);

  // R8: acknowledge always clears overrun
  a_r8_ack_clears_overrun: assert property (@(posedge clk) disable iff (!rst_q_n)
    host_ack |=> !overrun);

  // R8: overrun only rises over an unread update
  a_r8_overrun_needs_flag: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(overrun) |-> $past(af_flag));

  // R6: capture registers move only together with the flag
  a_r6_bytes_move_with_flag: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($past(rst_q_n) && (!$stable(af_byte) || !$stable(naf_byte))) |-> af_flag);
endmodule

bind e1_ts0_extract e1_ts0_extract_chk u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .rx_data   (rx_data),
  .link_data (link_data),
  .link_clk  (link_clk),
  .sync_out  (sync_out),
  .host_ack  (host_ack),
  .af_flag   (af_flag),
  .overrun   (overrun),
  .af_byte   (af_byte),
  .naf_byte  (naf_byte)
);

// File: tb/sim_e1_ts0_extract.sv
`timescale 1ns/1ps
module sim_e1_ts0_extract;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 256;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_data;
  logic       frame_strobe;
  logic       align_frame;
  logic [4:0] sa_mask;
  logic       host_ack;
  logic       link_data, link_clk, sync_out;
  logic [7:0] af_byte, naf_byte;
  logic       af_flag, overrun;

  int n_vec = 0;
  int n_bad = 0;

  // independent frame model
  bit m_locked = 0;
  int m_pos    = 0;
  bit m_af     = 0;
  bit e_valid  = 0;
  bit e_data, e_clk, e_sync;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_ts0_extract u0 (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .frame_strobe(frame_strobe),
    .align_frame(align_frame), .sa_mask(sa_mask), .host_ack(host_ack),
    .link_data(link_data), .link_clk(link_clk), .sync_out(sync_out),
    .af_byte(af_byte), .naf_byte(naf_byte), .af_flag(af_flag), .overrun(overrun)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one bit: check the outputs for the previous bit, then drive the next
  task automatic step(input bit d, input bit strb, input bit af, input bit ack);
    @(negedge clk);
    if (e_valid) begin
      check("R1 link_data", 16'(link_data), 16'(e_data));
      check("R3/R4 link_clk", 16'(link_clk), 16'(e_clk));
      check("R2 sync_out", 16'(sync_out), 16'(e_sync));
    end
    rx_data = d; frame_strobe = strb; align_frame = af; host_ack = ack;
    if (strb) begin
      m_locked = 1; m_pos = 0; m_af = af;
    end else if (m_locked) begin
      if (m_pos == FRAME-1) begin m_pos = 0; m_af = !m_af; end
      else m_pos++;
    end
    e_data = d; e_sync = strb;
    e_clk  = m_locked && !m_af && m_pos >= 3 && m_pos <= 7 && sa_mask[m_pos-3];
    e_valid = 1;
  endtask

  function automatic bit filler(input int i);
    return bit'(((i * 29) >> 2) & 1) ^ bit'(i & 1);
  endfunction

  task automatic send_frame(input bit strb, input bit af, input logic [7:0] ts0);
    for (int i = 0; i < FRAME; i++)
      step(i < 8 ? ts0[7-i] : filler(i), strb && i == 0, af, 1'b0);
  endtask

  task automatic do_ack();
    step(1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 0; rx_data = 0; frame_strobe = 0; align_frame = 0; sa_mask = 5'h1F; host_ack = 0;
    repeat (4) @(negedge clk);
    check("R10 reset link_clk", 16'(link_clk), 16'h0);
    check("R10 reset sync_out", 16'(sync_out), 16'h0);
    check("R10 reset flags", {14'h0, af_flag, overrun}, 16'h0);
    check("R10 reset bytes", {af_byte, naf_byte}, 16'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R10 after release link_data", 16'(link_data), 16'h0);
    check("R10 after release flags", {14'h0, af_flag, overrun}, 16'h0);
  endtask

  task automatic t_prelock();
    // R4: no clock before the first strobe, R1 data still mirrors
    for (int i = 0; i < 20; i++) step(filler(i + 3), 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_capture();
    sa_mask = 5'h00;
    send_frame(1'b1, 1'b0, 8'hC3);
    check("R6 lone non-align frame no flag", 16'(af_flag), 16'h0);
    check("R6 lone non-align frame no bytes", {af_byte, naf_byte}, 16'h0);
    send_frame(1'b1, 1'b1, 8'h9B);
    check("R6 no update after align frame", 16'(af_flag), 16'h0);
    send_frame(1'b1, 1'b0, 8'hD5);
    check("R5 af_byte bit order", 16'(af_byte), 16'h009B);
    check("R5 naf_byte bit order", 16'(naf_byte), 16'h00D5);
    check("R6 flag set", 16'(af_flag), 16'h1);
    check("R8 no overrun on first update", 16'(overrun), 16'h0);
    do_ack();
    check("R7 ack clears flag", 16'(af_flag), 16'h0);
    check("R7 bytes kept after ack", {af_byte, naf_byte}, 16'h9BD5);
  endtask

  task automatic t_overrun();
    sa_mask = 5'h0A;
    send_frame(1'b1, 1'b1, 8'h1B);
    send_frame(1'b1, 1'b0, 8'h6E);
    check("R8 flag without overrun", {14'h0, af_flag, overrun}, 16'h2);
    send_frame(1'b1, 1'b1, 8'h9B);
    send_frame(1'b1, 1'b0, 8'h41);
    check("R8 overrun set", {14'h0, af_flag, overrun}, 16'h3);
    check("R6 newest pair kept", {af_byte, naf_byte}, 16'h9B41);
    do_ack();
    check("R8 ack clears overrun and flag", {14'h0, af_flag, overrun}, 16'h0);
  endtask

  task automatic t_mask_sweep();
    for (int m = 0; m < 32; m++) begin
      sa_mask = 5'(m);
      send_frame(1'b1, 1'b1, 8'h1B);               // R4: no pulses here
      send_frame(1'b1, 1'b0, {3'b010, 5'(m ^ 5'h15)});  // R3: pulses per mask bit
      check("R5 naf_byte during sweep", 16'(naf_byte), 16'({3'b010, 5'(m ^ 5'h15)}));
    end
    do_ack();
    check("R7 cleared after sweep", {14'h0, af_flag, overrun}, 16'h0);
  endtask

  task automatic t_freerun();
    sa_mask = 5'h1F;
    send_frame(1'b1, 1'b1, 8'h9B);
    send_frame(1'b0, 1'b0, 8'h5A);   // R9: no strobe, type toggles on wrap
    check("R9 capture without strobe", {af_byte, naf_byte}, 16'h9B5A);
    check("R9 flag without strobe", 16'(af_flag), 16'h1);
    send_frame(1'b0, 1'b0, 8'h1B);   // R9: now an align frame by alternation
    check("R9 no update on free-run align frame", {af_byte, naf_byte}, 16'h9B5A);
    step(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_prelock();
    t_capture();
    t_overrun();
    t_mask_sweep();
    t_freerun();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule